// File: doc/BRIEF.md
# Add-Subtract-OR ALU with Zero Flag

This block is the combinational arithmetic-logic unit of a small load/store processor. Two 32-bit operands and a 2-bit operation code go in. A 32-bit result and a zero flag come out, with no clock in the path. Addition and subtraction share a single ripple-carry chain of one-bit full adders. For subtraction, the second operand is inverted by a row of XOR gates and the carry into bit 0 supplies the extra one. A bitwise OR path sits alongside the adder.

The zero flag is raised whenever the selected result is all zeros. Control logic outside the block tests two registers for equality by requesting a subtraction and looking at the flag. Sums and differences wrap modulo 2^32. The block reports neither overflow nor carry-out.

Top module: `alu_aso`

## Requirements
- R1: With opSel = 2'b00, result equals opA + opB modulo 2^WIDTH.
- R2: With opSel = 2'b01, result equals opA - opB modulo 2^WIDTH, formed as opA + ~opB + 1 on the shared adder.
- R3: With opSel = 2'b10, result equals the bitwise OR of opA and opB.
- R4: With opSel = 2'b11, result is all zeros and zero is 1, whatever the operands are.
- R5: zero is 1 exactly when result is all zeros, for every operation code.
- R6: A subtraction of equal operands gives zero = 1, and a subtraction of unequal operands gives zero = 0.
- R7: Arithmetic wraps without any signalling: 0xFFFFFFFF + 1 gives 0 with zero = 1, and 0 - 1 gives 0xFFFFFFFF.
- R8: result and zero depend only on the present inputs. A change on any input shows at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 2 | Operation: 00 add, 01 subtract, 10 OR, 11 force zero |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand; inverted internally for subtract |
| result | output | 32 | Selected result |
| zero | output | 1 | High when result is all zeros |

## Verification
The result and the zero flag are produced together on every input change. The interesting cases are those where both must be right at the same moment: a subtraction of equal operands, and a wrapping add that lands exactly on zero. The bench creates these cases by driving equal and unequal operand pairs and the wraparound corners. Each expected item in the scoreboard holds the result and the flag together, so a case passes only when both match in the same sample.

// File: rtl/alu_aso_pkg.sv
package alu_aso_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_OR   = 2'b10,
    OP_NONE = 2'b11
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic invertB;    // XOR row inverts operand B
    logic carryIn;    // carry into bit 0
    logic pickOr;     // select OR path instead of adder
    logic forceZero;  // drive result to zero
  } aluStrobe_t;

endpackage

// File: rtl/alu_aso_fa.sv
module alu_aso_fa (
  input  logic bitA,
  input  logic bitB,
  input  logic cIn,
  output logic sumBit,
  output logic cOut
);
  assign sumBit = bitA ^ bitB ^ cIn;
  assign cOut   = (bitA & bitB) | (cIn & (bitA ^ bitB));
endmodule

// File: rtl/alu_aso_ctrl.sv
module alu_aso_ctrl
  import alu_aso_pkg::*;
(
  input  logic [1:0]  opSel,
  output aluStrobe_t  strobe
);
  always_comb begin
    strobe = '0;
    case (aluOp_e'(opSel))
      OP_ADD:  strobe = '0;
      OP_SUB:  begin strobe.invertB = 1'b1; strobe.carryIn = 1'b1; end
      OP_OR:   strobe.pickOr = 1'b1;
      default: strobe.forceZero = 1'b1;
    endcase
  end

  always_comb begin
    AST_ONE_PATH: assert ($onehot0({strobe.pickOr, strobe.forceZero})); // R4
    AST_SUB_PAIR: assert (strobe.invertB == strobe.carryIn); // R2
  end
endmodule

// File: rtl/alu_aso_dp.sv
module alu_aso_dp
  import alu_aso_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam int CHAIN = WIDTH + 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sumVal;
  logic [WIDTH-1:0] orVal;
  logic [CHAIN-1:0] carry;

  // conditional inverter on operand B
  assign bEff     = opB ^ {WIDTH{strobe.invertB}};
  assign carry[0] = strobe.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rip
    alu_aso_fa u_fa (
      .bitA  (opA[i]),
      .bitB  (bEff[i]),
      .cIn   (carry[i]),
      .sumBit(sumVal[i]),
      .cOut  (carry[i+1])
    );
  end

  assign orVal = opA | opB;

  always_comb begin
    if (strobe.forceZero)   result = '0;
    else if (strobe.pickOr) result = orVal;
    else                    result = sumVal;
  end

  assign zero = ~|result;

  always_comb begin
    if (!strobe.invertB && !strobe.carryIn)
      AST_ADD_MATCH: assert (sumVal == WIDTH'(opA + opB)); // R1
    if (strobe.invertB && strobe.carryIn)
      AST_SUB_MATCH: assert (sumVal == WIDTH'(opA - opB)); // R2
    if (strobe.invertB && strobe.carryIn && !strobe.pickOr && !strobe.forceZero && opA == opB)
      AST_EQ_ZERO: assert (zero); // R6
    if (strobe.pickOr && !strobe.forceZero)
      AST_OR_COVER: assert ((result & opA) == opA && (result & opB) == opB); // R3
  end
endmodule

// File: rtl/alu_aso.sv
module alu_aso
  import alu_aso_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  aluStrobe_t strobe;

  alu_aso_ctrl u_ctrl (
    .opSel (opSel),
    .strobe(strobe)
  );

  alu_aso_dp #(.WIDTH(WIDTH)) u_dp (
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .result(result),
    .zero  (zero)
  );

  always_comb begin
    if (opSel == 2'b11)
      AST_FORCED_ZERO: assert (zero && result == '0); // R4
  end
endmodule

// File: tb/alu_aso_test.sv
module alu_aso_test;
  logic clk = 1'b0;
  logic rstDone = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  opSel = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic [31:0] expRes;
    logic        expZero;
    string       tag;
  } item_t;
  item_t sb[$];

  alu_aso uut (
    .opSel (opSel),
    .opA   (opA),
    .opB   (opB),
    .result(result),
    .zero  (zero)
  );

  task automatic drive(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    item_t it;
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    case (op)
      2'b00:   it.expRes = a + b;
      2'b01:   it.expRes = a - b;
      2'b10:   it.expRes = a | b;
      default: it.expRes = '0;
    endcase
    it.expZero = (it.expRes == 32'h0);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare at the rising edge after each drive
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (result !== it.expRes || zero !== it.expZero) begin
        errors++;
        $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
                 it.tag, result, zero, it.expRes, it.expZero);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected <=5000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstDone = 1'b1;
    // idle state: add of zeros gives zero (R5)
    checks++;
    if (result !== 32'h0 || zero !== 1'b1) begin
      errors++;
      $display("FAIL R5 idle: result=%h zero=%b expected 00000000 1", result, zero);
    end
    drive(2'b00, 32'd5, 32'd7, "R1 add small");
    drive(2'b00, 32'h1234_5678, 32'h0FED_CBA8, "R1 add carries");
    drive(2'b00, 32'h8000_0000, 32'h8000_0000, "R1 add top bits");
    drive(2'b01, 32'd100, 32'd58, "R2 sub");
    drive(2'b01, 32'h0000_0010, 32'h0000_0001, "R2 sub borrow");
    drive(2'b10, 32'hF0F0_0000, 32'h0F0F_00FF, "R3 or");
    drive(2'b10, 32'h0, 32'h0, "R3 R5 or zeros");
    drive(2'b11, 32'hDEAD_BEEF, 32'h1234_5678, "R4 none");
    drive(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 none ones");
    drive(2'b01, 32'hCAFE_F00D, 32'hCAFE_F00D, "R6 equal");
    drive(2'b01, 32'hCAFE_F00D, 32'hCAFE_F00C, "R6 unequal");
    drive(2'b01, 32'h0, 32'h8000_0000, "R6 unequal top");
    drive(2'b00, 32'hFFFF_FFFF, 32'h1, "R7 wrap add");
    drive(2'b01, 32'h0, 32'h1, "R7 wrap sub");
    drive(2'b10, 32'h0, 32'h1, "R5 or nonzero");
    // R8: change inputs without a clock edge and look at once
    @(negedge clk);
    opSel = 2'b00; opA = 32'd1; opB = 32'd2;
    #0.5;
    checks++;
    if (result !== 32'd3) begin
      errors++;
      $display("FAIL R8 first: result=%h expected 00000003", result);
    end
    opSel = 2'b01; opB = 32'd1;
    #0.5;
    checks++;
    if (result !== 32'd0 || zero !== 1'b1) begin
      errors++;
      $display("FAIL R8 second: result=%h zero=%b expected 00000000 1", result, zero);
    end
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule